// File: doc/BRIEF.md
# Virtual Carrier-Sense Deferral Timer

This block holds the virtual carrier-sense state of a wireless MAC station. An upstream frame parser offers each received frame as one beat on a valid/ready stream. The beat carries a 2-bit frame-kind tag and a 16-bit duration in microseconds. The duration is the time the sender expects the whole RTS-CTS-DATA-ACK exchange to take. The block keeps a countdown, called the vector. The vector is loaded from RTS, CTS and DATA durations and falls by one on each 1 µs tick strobe. The block tells the transmit logic to defer while the vector is non-zero or the physical medium reports busy.

An exchange watchdog is restarted by every frame that can load the vector. If no further such frame arrives within a programmable number of ticks while the vector is still running, the exchange is taken as broken. The vector is then cleared and a one-cycle timeout flag is raised. When the vector counts down to zero on its own and no backoff is in progress, the block pulses a transmit-start request.

The stream never applies back-pressure: `frm_ready` is held high and every beat with `frm_valid` high is consumed in the cycle it appears. The upstream side may therefore present a new beat in every cycle.

Top module: `nav_defer_timer`

## Requirements
- R1: Frame-kind codes are 0 = RTS, 1 = CTS, 2 = DATA and 3 = other. Only a beat with `frm_valid` high and a kind of 0, 1 or 2 is a qualifying frame. Kind 3 beats and cycles with `frm_valid` low leave the vector and the watchdog untouched. `frm_ready` is always high.
- R2: `defer` is high in every cycle in which `nav_count` is non-zero.
- R3: On a qualifying frame, the vector takes the frame's duration after that clock edge only if the duration is larger than the current count. Otherwise the count is kept, so a later frame never shortens the vector.
- R4: In a cycle with `us_tick` high and no qualifying frame, a non-zero vector drops by exactly one. A vector at zero stays at zero.
- R5: `phy_busy` high makes `defer` high in the same cycle, whatever the vector holds.
- R6: Each qualifying frame restarts the watchdog with `wd_period`. While the vector is non-zero, the tick that is number `wd_period` after the last qualifying frame clears the vector at that edge, and `xchg_timeout` is high for that one cycle. A period of 0 behaves as 1. A tick in the same cycle does not decrement instead.
- R7: `tx_start` is high for one cycle after the edge at which a tick takes the vector from 1 to 0, provided `backoff_busy` was low in that cycle. A vector cleared by the watchdog never produces `tx_start`.
- R8: In a cycle with a qualifying frame, that cycle's tick is not applied. A frame arriving at the moment the vector would expire therefore wins, and no `tx_start` follows.
- R9: A synchronous active-high `rst` clears the vector, the watchdog, `tx_start` and `xchg_timeout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frm_valid | input | 1 | Frame beat offered |
| frm_ready | output | 1 | Always high; beats are never stalled |
| frm_kind | input | 2 | Frame kind: 0 RTS, 1 CTS, 2 DATA, 3 other |
| frm_dur | input | DUR_W (16) | Exchange duration in microseconds |
| us_tick | input | 1 | One-cycle strobe once per microsecond |
| phy_busy | input | 1 | Physical medium busy |
| backoff_busy | input | 1 | Backoff in progress |
| wd_period | input | WD_W (16) | Watchdog length in ticks |
| nav_count | output | DUR_W (16) | Current vector value |
| defer | output | 1 | Transmission must wait |
| tx_start | output | 1 | One-cycle transmit-start request |
| xchg_timeout | output | 1 | One-cycle exchange-timeout flag |

## Verification
Three events can collide with the vector's natural countdown from 1 to 0: a qualifying frame, the watchdog's final tick, and backoff being high. The bench provokes each collision by holding `us_tick` high while the vector is at 1 and driving the competing input in that same cycle. It then reads `nav_count`, `tx_start` and `xchg_timeout` just after the edge. The outcome is judged against R8 (the frame wins, the count stays, no pulse), R6 (the watchdog clears the vector and flags a timeout, with no pulse) and R7 (backoff suppresses the pulse).

// File: rtl/nav_pkg.sv
package nav_pkg;
  typedef enum logic [1:0] {
    FK_RTS   = 2'd0,
    FK_CTS   = 2'd1,
    FK_DATA  = 2'd2,
    FK_OTHER = 2'd3
  } frame_kind_e;
endpackage

// File: rtl/nav_vector_cnt.sv
// Holds the vector; a frame can only lengthen it, the watchdog can wipe it.
module nav_vector_cnt #(
  parameter int DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [DUR_W-1:0] load_dur,
  input  logic             tick,
  input  logic             wipe,
  output logic [DUR_W-1:0] count,
  output logic             zero_hit
);
  localparam logic [DUR_W-1:0] ONE = DUR_W'(1);

  logic [DUR_W-1:0] nxt;

  always_comb begin
    nxt = count;
    if (load_en) begin
      if (load_dur > count) nxt = load_dur;
    end else if (wipe) begin
      nxt = '0;
    end else if (tick && count != '0) begin
      nxt = count - ONE;
    end
  end

  // natural expiry: only a plain tick from 1 counts
  assign zero_hit = !load_en && !wipe && tick && (count == ONE);

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= nxt;
  end
endmodule

// File: rtl/nav_xchg_watchdog.sv
// Counts ticks since the last qualifying frame while the vector runs.
module nav_xchg_watchdog #(
  parameter int WD_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic            tick,
  input  logic            nav_zero,
  input  logic [WD_W-1:0] period,
  output logic            expire
);
  localparam logic [WD_W-1:0] ONE = WD_W'(1);

  logic            armed;
  logic [WD_W-1:0] left;
  logic            last;

  assign last   = (left <= ONE);
  assign expire = armed && !nav_zero && tick && !restart && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      left  <= '0;
    end else if (restart) begin
      armed <= 1'b1;
      left  <= period;
    end else if (nav_zero) begin
      armed <= 1'b0;
    end else if (armed && tick) begin
      if (last) armed <= 1'b0;
      else      left  <= left - ONE;
    end
  end
endmodule

// File: rtl/nav_tx_gate.sv
// Registers the one-cycle event outputs.
module nav_tx_gate (
  input  logic clk,
  input  logic rst,
  input  logic zero_hit,
  input  logic backoff_busy,
  input  logic expire,
  output logic tx_start,
  output logic xchg_timeout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_start     <= 1'b0;
      xchg_timeout <= 1'b0;
    end else begin
      tx_start     <= zero_hit && !backoff_busy;
      xchg_timeout <= expire;
    end
  end
endmodule

// File: rtl/nav_defer_timer.sv
module nav_defer_timer #(
  parameter int DUR_W = 16,
  parameter int WD_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frm_valid,
  output logic             frm_ready,
  input  logic [1:0]       frm_kind,
  input  logic [DUR_W-1:0] frm_dur,
  input  logic             us_tick,
  input  logic             phy_busy,
  input  logic             backoff_busy,
  input  logic [WD_W-1:0]  wd_period,
  output logic [DUR_W-1:0] nav_count,
  output logic             defer,
  output logic             tx_start,
  output logic             xchg_timeout
);
  import nav_pkg::*;

  logic qualify;
  logic wd_expire;
  logic zero_hit;
  logic nav_zero;

  assign frm_ready = 1'b1;
  assign qualify   = frm_valid && frm_ready && (frm_kind != FK_OTHER);
  assign nav_zero  = (nav_count == '0);
  assign defer     = !nav_zero || phy_busy;

  nav_vector_cnt #(.DUR_W(DUR_W)) vec_i (
    .clk      (clk),
    .rst      (rst),
    .load_en  (qualify),
    .load_dur (frm_dur),
    .tick     (us_tick),
    .wipe     (wd_expire),
    .count    (nav_count),
    .zero_hit (zero_hit)
  );

  nav_xchg_watchdog #(.WD_W(WD_W)) wd_i (
    .clk      (clk),
    .rst      (rst),
    .restart  (qualify),
    .tick     (us_tick),
    .nav_zero (nav_zero),
    .period   (wd_period),
    .expire   (wd_expire)
  );

  nav_tx_gate gate_i (
    .clk          (clk),
    .rst          (rst),
    .zero_hit     (zero_hit),
    .backoff_busy (backoff_busy),
    .expire       (wd_expire),
    .tx_start     (tx_start),
    .xchg_timeout (xchg_timeout)
  );
endmodule

// File: rtl/nav_defer_timer_chk.sv
module nav_defer_timer_chk #(
  parameter int DUR_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             frm_valid,
  input logic             frm_ready,
  input logic [1:0]       frm_kind,
  input logic [DUR_W-1:0] frm_dur,
  input logic             phy_busy,
  input logic             backoff_busy,
  input logic [DUR_W-1:0] nav_count,
  input logic             defer,
  input logic             tx_start,
  input logic             xchg_timeout
);
  a_r1_ready_high: assert property (@(posedge clk) disable iff (rst)
    frm_ready);

  a_r2_defer_nonzero: assert property (@(posedge clk) disable iff (rst)
    (nav_count != '0) |-> defer);

  a_r5_phy_defer: assert property (@(posedge clk) disable iff (rst)
    phy_busy |-> defer);

  a_r3_lengthen: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && frm_ready && frm_kind != 2'd3 && frm_dur > nav_count)
      |=> (nav_count == $past(frm_dur)));

  a_r3_never_shorter: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && frm_kind != 2'd3) |=> (nav_count >= $past(nav_count)));

  a_r7_tx_at_zero: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> (nav_count == '0));

  a_r7_tx_no_backoff: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_start) |-> !$past(backoff_busy));

  a_r6_timeout_clears: assert property (@(posedge clk) disable iff (rst)
    xchg_timeout |-> (nav_count == '0));

  a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
    xchg_timeout |=> !xchg_timeout);

  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tx_start, xchg_timeout}));
endmodule

bind nav_defer_timer nav_defer_timer_chk #(.DUR_W(DUR_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .frm_valid    (frm_valid),
  .frm_ready    (frm_ready),
  .frm_kind     (frm_kind),
  .frm_dur      (frm_dur),
  .phy_busy     (phy_busy),
  .backoff_busy (backoff_busy),
  .nav_count    (nav_count),
  .defer        (defer),
  .tx_start     (tx_start),
  .xchg_timeout (xchg_timeout)
);

// File: tb/nav_defer_timer_tb_top.sv
`timescale 1ns/1ps
module nav_defer_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        frm_valid;
  logic        frm_ready;
  logic [1:0]  frm_kind;
  logic [15:0] frm_dur;
  logic        us_tick;
  logic        phy_busy;
  logic        backoff_busy;
  logic [15:0] wd_period;
  logic [15:0] nav_count;
  logic        defer;
  logic        tx_start;
  logic        xchg_timeout;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  nav_defer_timer dut_i (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_kind(frm_kind), .frm_dur(frm_dur), .us_tick(us_tick),
    .phy_busy(phy_busy), .backoff_busy(backoff_busy), .wd_period(wd_period),
    .nav_count(nav_count), .defer(defer), .tx_start(tx_start),
    .xchg_timeout(xchg_timeout)
  );

  typedef struct packed {
    logic        v;
    logic [1:0]  k;
    logic [15:0] d;
    logic        t;
    logic        bo;
    logic        phy;
    logic [15:0] e_cnt;
    logic        e_def;
    logic        e_tx;
    logic        e_to;
  } vec_t;

  localparam int NV = 17;
  // kinds: 0 RTS, 1 CTS, 2 DATA, 3 other; watchdog period 100 (never fires here)
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 16'd5,  1'b0, 1'b0, 1'b0, 16'd5, 1'b1, 1'b0, 1'b0}, // R3 load
    '{1'b0, 2'd0, 16'd0,  1'b1, 1'b0, 1'b0, 16'd4, 1'b1, 1'b0, 1'b0}, // R4
    '{1'b1, 2'd1, 16'd3,  1'b1, 1'b0, 1'b0, 16'd4, 1'b1, 1'b0, 1'b0}, // R3 R8 smaller kept
    '{1'b0, 2'd0, 16'd0,  1'b1, 1'b0, 1'b0, 16'd3, 1'b1, 1'b0, 1'b0}, // R4
    '{1'b0, 2'd0, 16'd0,  1'b1, 1'b0, 1'b1, 16'd2, 1'b1, 1'b0, 1'b0}, // R2
    '{1'b1, 2'd3, 16'd50, 1'b1, 1'b0, 1'b0, 16'd1, 1'b1, 1'b0, 1'b0}, // R1 other ignored
    '{1'b0, 2'd0, 16'd60, 1'b1, 1'b0, 1'b0, 16'd0, 1'b0, 1'b1, 1'b0}, // R1 R7
    '{1'b0, 2'd0, 16'd0,  1'b0, 1'b0, 1'b1, 16'd0, 1'b1, 1'b0, 1'b0}, // R5
    '{1'b1, 2'd2, 16'd2,  1'b0, 1'b0, 1'b0, 16'd2, 1'b1, 1'b0, 1'b0}, // R3 data
    '{1'b0, 2'd0, 16'd0,  1'b1, 1'b0, 1'b0, 16'd1, 1'b1, 1'b0, 1'b0}, // R4
    '{1'b0, 2'd0, 16'd0,  1'b1, 1'b1, 1'b0, 16'd0, 1'b0, 1'b0, 1'b0}, // R7 backoff
    '{1'b0, 2'd0, 16'd0,  1'b1, 1'b0, 1'b0, 16'd0, 1'b0, 1'b0, 1'b0}, // R4 saturate
    '{1'b1, 2'd0, 16'd1,  1'b0, 1'b0, 1'b0, 16'd1, 1'b1, 1'b0, 1'b0}, // R3
    '{1'b1, 2'd0, 16'd1,  1'b1, 1'b0, 1'b0, 16'd1, 1'b1, 1'b0, 1'b0}, // R8 frame wins
    '{1'b0, 2'd0, 16'd0,  1'b1, 1'b0, 1'b0, 16'd0, 1'b0, 1'b1, 1'b0}, // R7
    '{1'b0, 2'd0, 16'd0,  1'b0, 1'b0, 1'b0, 16'd0, 1'b0, 1'b0, 1'b0}, // R7 one cycle
    '{1'b1, 2'd1, 16'd7,  1'b0, 1'b0, 1'b0, 16'd7, 1'b1, 1'b0, 1'b0}  // R1 cts
  };

  task automatic step(input logic v, input logic [1:0] k, input logic [15:0] d,
                      input logic t, input logic bo, input logic phy);
    @(negedge clk);
    frm_valid = v; frm_kind = k; frm_dur = d;
    us_tick = t; backoff_busy = bo; phy_busy = phy;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [15:0] e_cnt,
                     input logic e_def, input logic e_tx, input logic e_to);
    checks++;
    if (nav_count !== e_cnt || defer !== e_def ||
        tx_start !== e_tx || xchg_timeout !== e_to) begin
      errors++;
      $display("FAIL %s: cnt/def/tx/to actual %0d/%0b/%0b/%0b expected %0d/%0b/%0b/%0b",
               tag, nav_count, defer, tx_start, xchg_timeout,
               e_cnt, e_def, e_tx, e_to);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; frm_valid = 1'b0; frm_kind = 2'd0; frm_dur = '0;
    us_tick = 1'b0; phy_busy = 1'b0; backoff_busy = 1'b0; wd_period = 16'd100;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset state", 16'd0, 1'b0, 1'b0, 1'b0);
    checks++;
    if (frm_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 ready: actual %0b expected 1", frm_ready);
    end
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].v, VECS[i].k, VECS[i].d, VECS[i].t, VECS[i].bo, VECS[i].phy);
      chk($sformatf("vector %0d (R1/R2/R3/R4/R5/R7/R8)", i),
          VECS[i].e_cnt, VECS[i].e_def, VECS[i].e_tx, VECS[i].e_to);
    end

    // R9: reset mid-count
    step(1'b1, 2'd0, 16'd9, 1'b0, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk("R9 reset mid-count", 16'd0, 1'b0, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b0;

    // R6: watchdog expiry on third tick
    wd_period = 16'd3;
    step(1'b1, 2'd0, 16'd100, 1'b0, 1'b0, 1'b0);
    step(1'b0, 2'd0, 16'd0, 1'b1, 1'b0, 1'b0);
    chk("R6 tick1", 16'd99, 1'b1, 1'b0, 1'b0);
    step(1'b0, 2'd0, 16'd0, 1'b1, 1'b0, 1'b0);
    step(1'b0, 2'd0, 16'd0, 1'b1, 1'b0, 1'b0);
    chk("R6 expiry", 16'd0, 1'b0, 1'b0, 1'b1);
    step(1'b0, 2'd0, 16'd0, 1'b0, 1'b0, 1'b0);
    chk("R6 flag one cycle", 16'd0, 1'b0, 1'b0, 1'b0);

    // R6: restart by a later frame
    step(1'b1, 2'd0, 16'd100, 1'b0, 1'b0, 1'b0);
    step(1'b0, 2'd0, 16'd0, 1'b1, 1'b0, 1'b0);
    step(1'b0, 2'd0, 16'd0, 1'b1, 1'b0, 1'b0);
    step(1'b1, 2'd1, 16'd10, 1'b0, 1'b0, 1'b0);
    chk("R6 R3 restart keeps count", 16'd98, 1'b1, 1'b0, 1'b0);
    step(1'b0, 2'd0, 16'd0, 1'b1, 1'b0, 1'b0);
    step(1'b0, 2'd0, 16'd0, 1'b1, 1'b0, 1'b0);
    chk("R6 not yet", 16'd96, 1'b1, 1'b0, 1'b0);
    step(1'b0, 2'd0, 16'd0, 1'b1, 1'b0, 1'b0);
    chk("R6 expiry after restart", 16'd0, 1'b0, 1'b0, 1'b1);

    // R6 R7: watchdog final tick coincides with natural expiry
    wd_period = 16'd2;
    step(1'b1, 2'd2, 16'd2, 1'b0, 1'b0, 1'b0);
    step(1'b0, 2'd0, 16'd0, 1'b1, 1'b0, 1'b0);
    chk("R6 pre-collision", 16'd1, 1'b1, 1'b0, 1'b0);
    step(1'b0, 2'd0, 16'd0, 1'b1, 1'b0, 1'b0);
    chk("R6 R7 watchdog beats expiry", 16'd0, 1'b0, 1'b0, 1'b1);

    // R6: period 0 acts as 1
    wd_period = 16'd0;
    step(1'b1, 2'd0, 16'd20, 1'b0, 1'b0, 1'b0);
    step(1'b0, 2'd0, 16'd0, 1'b1, 1'b0, 1'b0);
    chk("R6 period zero", 16'd0, 1'b0, 1'b0, 1'b1);

    // R1: invalid beat ignored
    step(1'b0, 2'd0, 16'd30, 1'b0, 1'b0, 1'b0);
    chk("R1 valid low ignored", 16'd0, 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule